// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This watchdog is controlled through one write port. Each write carries an enable bit and a short key. A write with the enable bit set starts a stopped watchdog, and the key it carries becomes the current key. While the watchdog runs, only a write whose key equals the bitwise inverse of the current key counts as service. With the enable bit set, that write restarts the timeout and the inverted value becomes the new key. With the enable bit clear, it stops the watchdog. Any other write while the watchdog runs only replaces the stored key; the timeout keeps counting.

Expiry has two stages. If the first timeout runs out before any service, the block raises a non-maskable interrupt request, which stays high. The second, shorter timeout then starts. If that one also runs out, the block emits a one-cycle chip-reset request and returns to the stopped state. Both timeout lengths are parameters counted in clock cycles. The running flag and the current key can be read back on status outputs.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is stopped: running_o=0, nmi_o=0, chip_rst_o=0, key_o=0.
- R2: While stopped, a write with wr_en_i=0 has no effect on running_o or key_o, whatever key it carries.
- R3: While stopped, a write with wr_en_i=1 and key K sets running_o=1 in the cycle after the write edge, and key_o becomes K.
- R4: While running, a write with wr_en_i=0 and wr_key_i equal to ~key_o stops the watchdog (running_o=0, nmi_o=0). After that, no chip_rst_o pulse occurs.
- R5: While running, a write with wr_en_i=1 and wr_key_i equal to ~key_o clears nmi_o and restarts the full first timeout. key_o takes the written (inverted) value.
- R6: While running, a write whose key is not ~key_o replaces key_o with the written key and does not restart the timeout.
- R7: If no valid service arrives, nmi_o rises exactly T1_CYCLES clock edges after the edge of the start or restart write. It stays high until a valid service or the chip reset.
- R8: If nmi_o is high and no valid service arrives, chip_rst_o is high for exactly one cycle, T2_CYCLES edges after nmi_o rose. On that same edge running_o and nmi_o drop to 0.
- R9: A valid restart write that lands on the edge where the first timeout would expire takes priority: nmi_o stays 0 and the full timeout restarts.
- R10: key_o changes only on a write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Control write strobe |
| wr_en_i | input | 1 | Enable bit of the write |
| wr_key_i | input | KEY_W | Key field of the write |
| nmi_o | output | 1 | Non-maskable interrupt request, level |
| chip_rst_o | output | 1 | Chip reset request, one-cycle pulse |
| running_o | output | 1 | Status: watchdog started |
| key_o | output | KEY_W | Status: current key |

## Verification
The assertions check four rules on every cycle. The reset request always lasts a single cycle. A raised NMI persists unless it is serviced or the chip reset fires. Valid stop and restart writes take effect on the next cycle. The key holds still and a stopped watchdog stays stopped across enable-clear writes. Only the bench's scenarios can show the exact timeout lengths of both stages, that a wrong key does not restart the count, and that a restart landing on the expiry edge wins over the expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_ARMED = 2'd1,
    WD_NMI   = 2'd2
  } wd_phase_e;
endpackage

// File: rtl/wdog_keyctl.sv
module wdog_keyctl #(
  parameter int KEY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic             running_i,
  output logic             start_o,
  output logic             kick_o,
  output logic             stop_o,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] key_q;
  logic             key_ok;

  assign key_ok  = (wr_key_i == ~key_q);
  assign start_o = wr_i && wr_en_i && !running_i;
  assign kick_o  = wr_i && wr_en_i && running_i && key_ok;
  assign stop_o  = wr_i && !wr_en_i && running_i && key_ok;
  assign key_o   = key_q;

  // any write while running rewrites the key; only a start does so while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   key_q <= '0;
    else if (start_o)              key_q <= wr_key_i;
    else if (wr_i && running_i)    key_q <= wr_key_i;
  end

  // R2
  property stopped_noop_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (!running_i && wr_i && !wr_en_i) |=> (key_q == $past(key_q));
  endproperty
  stopped_noop_chk: assert property (stopped_noop_p);

  // R10
  property key_hold_p;
    @(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(key_q);
  endproperty
  key_hold_chk: assert property (key_hold_p);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int T1_CYCLES = 5000000,
  parameter int T2_CYCLES = 165000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic kick_i,
  input  logic stop_i,
  output logic running_o,
  output logic nmi_o,
  output logic chip_rst_o
);
  localparam int MAXC = (T1_CYCLES > T2_CYCLES) ? T1_CYCLES : T2_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] T1_LOAD = CW'(T1_CYCLES - 1);
  localparam logic [CW-1:0] T2_LOAD = CW'(T2_CYCLES - 1);

  wd_phase_e     phase_q;
  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= WD_OFF;
      cnt_q   <= '0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (start_i || kick_i) begin
        phase_q <= WD_ARMED;
        cnt_q   <= T1_LOAD;
      end else if (stop_i) begin
        phase_q <= WD_OFF;
      end else begin
        unique case (phase_q)
          WD_ARMED:
            if (cnt_q == '0) begin
              phase_q <= WD_NMI;
              cnt_q   <= T2_LOAD;
            end else cnt_q <= cnt_q - 1'b1;
          WD_NMI:
            if (cnt_q == '0) begin
              phase_q <= WD_OFF;
              rst_q   <= 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  assign running_o  = (phase_q != WD_OFF);
  assign nmi_o      = (phase_q == WD_NMI);
  assign chip_rst_o = rst_q;

  // R8
  property rst_pulse_p;
    @(posedge clk_i) disable iff (!rst_ni)
      chip_rst_o |=> !chip_rst_o;
  endproperty
  rst_pulse_chk: assert property (rst_pulse_p);

  // R7
  property nmi_hold_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (nmi_o && !kick_i && !stop_i) |=> (nmi_o || chip_rst_o);
  endproperty
  nmi_hold_chk: assert property (nmi_hold_p);

  // R8
  property rst_from_nmi_p;
    @(posedge clk_i) disable iff (!rst_ni)
      $rose(chip_rst_o) |-> ($past(nmi_o) && !running_o);
  endproperty
  rst_from_nmi_chk: assert property (rst_from_nmi_p);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int KEY_W     = 3,
  parameter int T1_CYCLES = 5000000,
  parameter int T2_CYCLES = 165000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  output logic             nmi_o,
  output logic             chip_rst_o,
  output logic             running_o,
  output logic [KEY_W-1:0] key_o
);
  logic start_w, kick_w, stop_w;

  wdog_keyctl #(.KEY_W(KEY_W)) u_keyctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_en_i   (wr_en_i),
    .wr_key_i  (wr_key_i),
    .running_i (running_o),
    .start_o   (start_w),
    .kick_o    (kick_w),
    .stop_o    (stop_w),
    .key_o     (key_o)
  );

  wdog_timer #(.T1_CYCLES(T1_CYCLES), .T2_CYCLES(T2_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .kick_i     (kick_w),
    .stop_i     (stop_w),
    .running_o  (running_o),
    .nmi_o      (nmi_o),
    .chip_rst_o (chip_rst_o)
  );

  // R5
  property restart_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (running_o && wr_i && wr_en_i && (wr_key_i == ~key_o)) |=> (running_o && !nmi_o);
  endproperty
  restart_chk: assert property (restart_p);

  // R4
  property stop_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (running_o && wr_i && !wr_en_i && (wr_key_i == ~key_o)) |=> (!running_o && !nmi_o && !chip_rst_o);
  endproperty
  stop_chk: assert property (stop_p);

  // R2
  property stay_off_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (!running_o && !(wr_i && wr_en_i)) |=> !running_o;
  endproperty
  stay_off_chk: assert property (stay_off_p);
endmodule

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 3;
  localparam int T1 = 20;
  localparam int T2 = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [KW-1:0] wr_key_i = '0;
  logic          nmi_o, chip_rst_o, running_o;
  logic [KW-1:0] key_o;

  keyed_wdog #(.KEY_W(KW), .T1_CYCLES(T1), .T2_CYCLES(T2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_en_i(wr_en_i),
    .wr_key_i(wr_key_i), .nmi_o(nmi_o), .chip_rst_o(chip_rst_o),
    .running_o(running_o), .key_o(key_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int            at;
    logic          run;
    logic          nmi;
    logic          rst;
    logic [KW-1:0] key;
    string         req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare due items at the falling edge
  always @(negedge clk_i) begin
    exp_t e;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.at != cyc || running_o !== e.run || nmi_o !== e.nmi ||
          chip_rst_o !== e.rst || key_o !== e.key) begin
        fails++;
        $display("FAIL %s cyc=%0d: got run=%b nmi=%b rst=%b key=%0d, exp run=%b nmi=%b rst=%b key=%0d (due %0d)",
                 e.req, cyc, running_o, nmi_o, chip_rst_o, key_o,
                 e.run, e.nmi, e.rst, e.key, e.at);
      end
    end
  end

  task automatic expect_at(input int at, input logic run, input logic nmi,
                           input logic rst, input logic [KW-1:0] key, input string req);
    exp_t e;
    e.at = at; e.run = run; e.nmi = nmi; e.rst = rst; e.key = key; e.req = req;
    q.push_back(e);
  endtask

  task automatic write(input logic en, input logic [KW-1:0] k);
    wr_i = 1'b1; wr_en_i = en; wr_key_i = k;
    @(negedge clk_i);
    wr_i = 1'b0; wr_en_i = 1'b0; wr_key_i = '0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run hung at cyc=%0d, expected completion", cyc);
    summary();
  end

  initial begin
    int b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_at(cyc + 1, 0, 0, 0, 3'd0, "R1");
    wait_until(cyc + 2);

    write(1'b0, 3'd5);
    expect_at(cyc + 1, 0, 0, 0, 3'd0, "R2");
    wait_until(cyc + 2);

    write(1'b1, 3'd3);
    b = cyc;
    expect_at(b + 1, 1, 0, 0, 3'd3, "R3");
    wait_until(b + 5);
    write(1'b1, 3'd6);                       // not ~3: rekey only
    expect_at(b + 7, 1, 0, 0, 3'd6, "R6");
    expect_at(b + T1 - 1, 1, 0, 0, 3'd6, "R6");
    expect_at(b + T1, 1, 1, 0, 3'd6, "R7");
    wait_until(b + T1 + 2);

    write(1'b1, 3'd1);                       // ~6: restart
    b = cyc;
    expect_at(b + 1, 1, 0, 0, 3'd1, "R5");
    expect_at(b + T1 - 1, 1, 0, 0, 3'd1, "R5");
    expect_at(b + T1, 1, 1, 0, 3'd1, "R5");
    wait_until(b + T1 + 2);

    write(1'b0, 3'd6);                       // ~1: stop
    b = cyc;
    expect_at(b + 1, 0, 0, 0, 3'd6, "R4");
    expect_at(b + T1 + T2 + 2, 0, 0, 0, 3'd6, "R4");
    wait_until(b + T1 + T2 + 3);

    write(1'b1, 3'd2);
    b = cyc;
    expect_at(b + T1, 1, 1, 0, 3'd2, "R7");
    expect_at(b + T1 + T2 - 1, 1, 1, 0, 3'd2, "R10");
    expect_at(b + T1 + T2, 0, 0, 1, 3'd2, "R8");
    expect_at(b + T1 + T2 + 1, 0, 0, 0, 3'd2, "R8");
    wait_until(b + T1 + T2 + 3);

    write(1'b1, 3'd0);
    b = cyc;
    expect_at(b + T1, 1, 0, 0, 3'd7, "R9");
    expect_at(b + 2 * T1, 1, 1, 0, 3'd7, "R9");
    wait_until(b + T1 - 1);
    write(1'b1, 3'd7);                       // lands on expiry edge
    wait_until(b + 2 * T1 + 1);
    write(1'b0, 3'd0);
    expect_at(cyc + 1, 0, 0, 0, 3'd0, "R4");
    wait_until(cyc + 3);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    summary();
  end
endmodule